// File: doc/BRIEF.md
# Extended Divide and Multiply Unit

This block performs four long arithmetic operations on a 16-bit register set: a signed 16-by-16 divide, an unsigned and a signed 32-by-16 divide, and a signed 16-by-16 multiply. The surrounding datapath presents the current D, X and Y register values with an operation code and a start strobe. Some cycles later the block returns the new D, X and Y values and the N, Z, V and C condition flags, and marks that moment with a one-cycle done pulse.

The divides share one iterative shift-and-subtract core. It works on magnitudes and produces one quotient bit per clock across a 32-bit dividend. Signs are applied to the results afterwards. The multiply is a single combinational product taken in the cycle after acceptance.

The interface is plain control, not a stream. A start is accepted only while busy is low. The block has no back-pressure on its outputs: the results stay in their registers until the next done pulse replaces them. The caller may issue the next start in the same cycle that done is high.

Top module: `exarith_unit`

## Requirements
- R1: Operation code 0 is the signed 16/16 divide. D is the dividend and X is the divisor. The remainder is written to D, the quotient to X, and Y is returned unchanged.
- R2: Operation code 1 is the unsigned 32/16 divide and code 2 is the signed 32/16 divide. The dividend is Y:D, with Y as the high half, and X is the divisor. The quotient is written to Y, the remainder to D, and X is returned unchanged.
- R3: Signed divides truncate the quotient toward zero. The remainder carries the sign of the dividend.
- R4: When the divisor X is zero, a divide returns D, X and Y unchanged, sets C to 1 and clears N, Z and V.
- R5: When the divisor is non-zero, a divide clears C. Z is set when the full quotient is zero, and N equals bit 15 of the quotient.
- R6: V is set when the quotient does not fit in 16 bits: above 65535 for code 1, and outside -32768..32767 for codes 0 and 2. In that case the register still receives the low 16 bits of the quotient.
- R7: Operation code 3 forms the signed 32-bit product of D and Y. It writes the high half to Y and the low half to D, and returns X unchanged. Z is set for a zero product, N equals product bit 31, C equals product bit 15, and V is 0.
- R8: Take the edge that accepts a start as edge 0. Busy is high from edge 0 until done is raised. Done is high for one cycle after edge 33 for a divide with a non-zero divisor, and after edge 1 for a multiply or a zero divisor. A new start may be accepted in the cycle done is high.
- R9: A start asserted while busy is high is ignored. It changes neither the results nor the timing of the operation in flight.
- R10: Done is a one-cycle pulse. D, X, Y and the flags change only at the edge that raises done, and hold between done pulses.
- R11: During reset, busy, done, all register outputs and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request an operation; taken only when busy is low |
| op | input | 2 | Operation code: 0 sdiv16, 1 udiv32, 2 sdiv32, 3 smul16 |
| d_in | input | 16 | Current D register |
| x_in | input | 16 | Current X register |
| y_in | input | 16 | Current Y register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| d_out | output | 16 | New D register value |
| x_out | output | 16 | New X register value |
| y_out | output | 16 | New Y register value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The assertions check on every cycle that:
- done lasts exactly one cycle;
- busy follows an accepted start;
- operands captured for an operation are not disturbed by a start issued while busy;
- outputs move only on a done edge;
- the partial remainder stays below the divisor;
- the zero-divisor and multiply flag rules hold.

Only the bench scenarios can show that the quotient, remainder, product and overflow values are arithmetically correct. These scenarios cover mixed signs, the most negative operands and quotients too wide for 16 bits, and the bench compares each result against an integer model.

// File: rtl/exarith_pkg.sv
package exarith_pkg;
  typedef enum logic [1:0] {
    OP_SDIV16 = 2'd0,
    OP_UDIV32 = 2'd1,
    OP_SDIV32 = 2'd2,
    OP_SMUL16 = 2'd3
  } xop_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } xflags_t;
endpackage

// File: rtl/exarith_divcore.sv
module exarith_divcore #(
  parameter int W  = 16,
  parameter int QW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [QW-1:0] dividend,
  input  logic [W-1:0]  divisor,
  output logic          last_step,
  output logic [QW-1:0] quo,
  output logic [W-1:0]  rem
);
  localparam int CW = $clog2(QW);

  logic [QW-1:0] q_r;
  logic [W-1:0]  r_r;
  logic [W-1:0]  dv_r;
  logic [CW-1:0] cnt_r;
  logic          run_r;
  logic [W:0]    trial;

  assign trial     = {r_r, q_r[QW-1]} - {1'b0, dv_r};
  assign last_step = run_r && (cnt_r == CW'(QW - 1));
  assign quo       = q_r;
  assign rem       = r_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= '0;
      r_r   <= '0;
      dv_r  <= '0;
      cnt_r <= '0;
      run_r <= 1'b0;
    end else if (load) begin
      q_r   <= dividend;
      r_r   <= '0;
      dv_r  <= divisor;
      cnt_r <= '0;
      run_r <= 1'b1;
    end else if (run_r) begin
      if (!trial[W]) begin
        r_r <= trial[W-1:0];
        q_r <= {q_r[QW-2:0], 1'b1};
      end else begin
        r_r <= {r_r[W-2:0], q_r[QW-1]};
        q_r <= {q_r[QW-2:0], 1'b0};
      end
      cnt_r <= cnt_r + 1'b1;
      if (last_step) run_r <= 1'b0;
    end
  end

  // R5: the partial remainder never reaches the divisor while iterating
  p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_r |-> (r_r < dv_r));
endmodule

// File: rtl/exarith_mul.sv
module exarith_mul #(
  parameter int W  = 16,
  parameter int QW = 2 * W
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [QW-1:0] prod
);
  logic signed [QW-1:0] p_s;
  assign p_s  = $signed(a) * $signed(b);
  assign prod = p_s;
endmodule

// File: rtl/exarith_post.sv
module exarith_post
  import exarith_pkg::*;
#(
  parameter int W  = 16,
  parameter int QW = 2 * W
) (
  input  xop_e          op,
  input  logic          dz,
  input  logic          qneg,
  input  logic          rneg,
  input  logic [QW-1:0] quo,
  input  logic [W-1:0]  rem,
  input  logic [QW-1:0] prod,
  input  logic [W-1:0]  d,
  input  logic [W-1:0]  x,
  input  logic [W-1:0]  y,
  output logic [W-1:0]  d_o,
  output logic [W-1:0]  x_o,
  output logic [W-1:0]  y_o,
  output xflags_t       fl_o
);
  localparam logic [QW-1:0] LIM_POS = {{(QW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic [QW-1:0] LIM_NEG = LIM_POS + 1'b1;

  logic [QW-1:0] qs;
  logic [W-1:0]  rs;
  logic          ovf;

  assign qs = qneg ? (~quo + 1'b1) : quo;
  assign rs = rneg ? (~rem + 1'b1) : rem;

  always_comb begin
    if (op == OP_UDIV32) ovf = |quo[QW-1:W];
    else if (qneg)       ovf = quo > LIM_NEG;
    else                 ovf = quo > LIM_POS;
  end

  always_comb begin
    d_o  = d;
    x_o  = x;
    y_o  = y;
    fl_o = '0;
    if (op == OP_SMUL16) begin
      y_o    = prod[QW-1:W];
      d_o    = prod[W-1:0];
      fl_o.n = prod[QW-1];
      fl_o.z = (prod == '0);
      fl_o.c = prod[W-1];
    end else if (dz) begin
      fl_o.c = 1'b1;
    end else begin
      d_o = rs;
      if (op == OP_SDIV16) x_o = qs[W-1:0];
      else                 y_o = qs[W-1:0];
      fl_o.n = qs[W-1];
      fl_o.z = (quo == '0);
      fl_o.v = ovf;
    end
  end
endmodule

// File: rtl/exarith_unit.sv
module exarith_unit
  import exarith_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] d_in,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] d_out,
  output logic [W-1:0] x_out,
  output logic [W-1:0] y_out,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v,
  output logic         flag_c
);
  localparam int QW = 2 * W;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_e;

  st_e           state;
  xop_e          op_in, op_q;
  logic [W-1:0]  d_q, x_q, y_q;
  logic          dz_q, qneg_q, rneg_q;
  logic          acc, sgn, is_div, xz, dvd_neg, dsr_neg, core_load, core_last;
  logic [QW-1:0] dvd, dvd_mag, quo, prod;
  logic [W-1:0]  dsr_mag, rem, d_n, x_n, y_n;
  xflags_t       fl_n;

  assign op_in     = xop_e'(op);
  assign busy      = (state != S_IDLE);
  assign acc       = start && !busy;
  assign sgn       = (op_in != OP_UDIV32);
  assign is_div    = (op_in != OP_SMUL16);
  assign xz        = (x_in == '0);
  assign dvd       = (op_in == OP_SDIV16) ? {{W{d_in[W-1]}}, d_in} : {y_in, d_in};
  assign dvd_neg   = sgn && dvd[QW-1];
  assign dvd_mag   = dvd_neg ? (~dvd + 1'b1) : dvd;
  assign dsr_neg   = sgn && x_in[W-1];
  assign dsr_mag   = dsr_neg ? (~x_in + 1'b1) : x_in;
  assign core_load = acc && is_div && !xz;

  exarith_divcore #(.W(W), .QW(QW)) u_div (
    .clk(clk), .rst_n(rst_n), .load(core_load), .dividend(dvd_mag),
    .divisor(dsr_mag), .last_step(core_last), .quo(quo), .rem(rem)
  );

  exarith_mul #(.W(W), .QW(QW)) u_mul (.a(d_q), .b(y_q), .prod(prod));

  exarith_post #(.W(W), .QW(QW)) u_post (
    .op(op_q), .dz(dz_q), .qneg(qneg_q), .rneg(rneg_q), .quo(quo), .rem(rem),
    .prod(prod), .d(d_q), .x(x_q), .y(y_q),
    .d_o(d_n), .x_o(x_n), .y_o(y_n), .fl_o(fl_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= OP_SDIV16;
      d_q    <= '0;
      x_q    <= '0;
      y_q    <= '0;
      dz_q   <= 1'b0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
      done   <= 1'b0;
      d_out  <= '0;
      x_out  <= '0;
      y_out  <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
      flag_c <= 1'b0;
    end else begin
      done <= (state == S_FIN);
      case (state)
        S_IDLE: if (acc) begin
          op_q   <= op_in;
          d_q    <= d_in;
          x_q    <= x_in;
          y_q    <= y_in;
          dz_q   <= is_div && xz;
          qneg_q <= dvd_neg ^ dsr_neg;
          rneg_q <= dvd_neg;
          state  <= (is_div && !xz) ? S_RUN : S_FIN;
        end
        S_RUN: if (core_last) state <= S_FIN;
        S_FIN: begin
          state  <= S_IDLE;
          d_out  <= d_n;
          x_out  <= x_n;
          y_out  <= y_n;
          flag_n <= fl_n.n;
          flag_z <= fl_n.z;
          flag_v <= fl_n.v;
          flag_c <= fl_n.c;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> ($stable(op_q) && $stable(d_q) && $stable(x_q) && $stable(y_q)));

  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((d_out != $past(d_out)) || (x_out != $past(x_out)) || (y_out != $past(y_out))) |-> done);

  p_zero_div_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dz_q) |-> (flag_c && !flag_v && d_out == d_q && x_out == x_q && y_out == y_q));

  p_mul_no_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_SMUL16) |-> (!flag_v && x_out == x_q));
endmodule

// File: tb/exarith_unit_tb_top.sv
module exarith_unit_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [15:0] d_in = '0, x_in = '0, y_in = '0;
  logic        busy, done, flag_n, flag_z, flag_v, flag_c;
  logic [15:0] d_out, x_out, y_out;

  exarith_unit #(.W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .d_in(d_in), .x_in(x_in),
    .y_in(y_in), .busy(busy), .done(done), .d_out(d_out), .x_out(x_out),
    .y_out(y_out), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  always #5 clk = ~clk;

  int    checks = 0, errors = 0;
  bit    seen_edge = 0, finished = 0;
  string ign = "";

  bit          m_busy = 0, m_done = 0;
  int          m_cnt = 0;
  logic [15:0] m_d = '0, m_x = '0, m_y = '0, p_d, p_x, p_y;
  bit          m_n = 0, m_z = 0, m_v = 0, m_c = 0, p_n, p_z, p_v, p_c;
  string       m_rtag = "R11", m_ftag = "R11", m_vtag = "R11";
  string       p_rtag, p_ftag, p_vtag;

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Behavioural reference: predicts the results of an accepted operation
  function automatic int model_accept(logic [1:0] o, logic [15:0] d, logic [15:0] x, logic [15:0] y);
    longint a, b, q, r, p;
    p_x = x; p_y = y; p_d = d;
    p_n = 0; p_z = 0; p_v = 0; p_c = 0;
    if (o == 2'd3) begin
      p = longint'($signed(d)) * longint'($signed(y));
      p_y = p[31:16]; p_d = p[15:0];
      p_n = p[31]; p_z = (p == 0); p_c = p[15];
      p_rtag = "R7"; p_ftag = "R7"; p_vtag = "R7";
      return 1;
    end
    if (o == 2'd0) begin
      a = longint'($signed(d)); b = longint'($signed(x));
    end else if (o == 2'd1) begin
      a = longint'({y, d}); b = longint'(x);
    end else begin
      a = longint'($signed({y, d})); b = longint'($signed(x));
    end
    if (b == 0) begin
      p_c = 1;
      p_rtag = "R4"; p_ftag = "R4"; p_vtag = "R4";
      return 1;
    end
    q = a / b;  // truncation toward zero, remainder follows dividend (R3)
    r = a % b;
    p_d = r[15:0];
    if (o == 2'd0) p_x = q[15:0];
    else           p_y = q[15:0];
    p_n = q[15];
    p_z = (q == 0);
    p_v = (o == 2'd1) ? (q > 65535) : (q > 32767 || q < -32768);
    p_rtag = (o == 2'd1) ? "R2" : ((a < 0 || b < 0) ? "R3" : ((o == 2'd0) ? "R1" : "R2"));
    p_ftag = "R5";
    p_vtag = "R6";
    return 33;
  endfunction

  always @(posedge clk) begin
    seen_edge <= 1;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0;
      m_d = '0; m_x = '0; m_y = '0;
      m_n = 0; m_z = 0; m_v = 0; m_c = 0;
    end else if (m_busy) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_busy = 0; m_done = 1;
        m_d = p_d; m_x = p_x; m_y = p_y;
        m_n = p_n; m_z = p_z; m_v = p_v; m_c = p_c;
        m_rtag = p_rtag; m_ftag = p_ftag; m_vtag = p_vtag;
      end
    end else begin
      m_done = 0;
      if (start) begin
        m_cnt  = model_accept(op, d_in, x_in, y_in);
        m_busy = 1;
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    string t, rt, ft, vt;
    if (seen_edge && !finished) begin
      t  = !rst_n ? "R11" : ((ign != "") ? ign : "R8");
      rt = !rst_n ? "R11" : ((ign != "") ? ign : m_rtag);
      ft = !rst_n ? "R11" : ((ign != "") ? ign : m_ftag);
      vt = !rst_n ? "R11" : ((ign != "") ? ign : m_vtag);
      chk(t, "busy", 16'(busy), 16'(m_busy));
      chk(t, "done", 16'(done), 16'(m_done));
      chk(rt, "d_out", d_out, m_d);
      chk(rt, "x_out", x_out, m_x);
      chk(rt, "y_out", y_out, m_y);
      chk(ft, "flag_n", 16'(flag_n), 16'(m_n));
      chk(ft, "flag_z", 16'(flag_z), 16'(m_z));
      chk(vt, "flag_v", 16'(flag_v), 16'(m_v));
      chk(ft, "flag_c", 16'(flag_c), 16'(m_c));
    end
  end

  task automatic run_op(logic [1:0] o, logic [15:0] d, logic [15:0] x, logic [15:0] y);
    while (busy) @(negedge clk);
    op = o; d_in = d; x_in = x; y_in = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R8 watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);   // R11: reset values compared above
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R3 / R6: signed 16/16
    run_op(2'd0, 16'd7, 16'd2, 16'h1234);
    run_op(2'd0, -16'sd7, 16'd2, 16'h0);
    run_op(2'd0, 16'd7, -16'sd2, 16'h5555);
    run_op(2'd0, 16'h8000, 16'hFFFF, 16'h0001);   // R6 overflow
    run_op(2'd0, 16'd3, 16'd9, 16'h0);            // R5 zero quotient
    run_op(2'd0, 16'd5, 16'd0, 16'hABCD);         // R4
    // R2: unsigned 32/16
    run_op(2'd1, 16'h86A0, 16'd3, 16'h0001);
    run_op(2'd1, 16'h5678, 16'h0010, 16'h1234);   // R6 wide quotient
    run_op(2'd1, 16'd5, 16'd7, 16'h0000);
    run_op(2'd1, 16'hFFFF, 16'hFFFF, 16'hFFFE);
    run_op(2'd1, 16'h1111, 16'd0, 16'h2222);      // R4
    // R2 / R3 signed 32/16
    run_op(2'd2, 16'h7960, 16'd7, 16'hFFFE);
    run_op(2'd2, 16'hFFFF, 16'hFFFF, 16'h7FFF);   // R6
    run_op(2'd2, 16'h0000, 16'h0001, 16'h8000);
    run_op(2'd2, 16'h8000, 16'hFFFF, 16'hFFFF);   // exactly -32768/... edge
    run_op(2'd2, 16'h0000, 16'h8000, 16'hC000);
    // R7 multiply
    run_op(2'd3, 16'd300, 16'h0, -16'sd2);
    run_op(2'd3, 16'h8000, 16'h7777, 16'h8000);
    run_op(2'd3, 16'h0000, 16'h1, 16'd5);
    run_op(2'd3, 16'h0100, 16'h2, 16'h0080);
    // R9: start held while busy with other operands
    op = 2'd1; d_in = 16'd1000; x_in = 16'd7; y_in = 16'd0; start = 1'b1;
    @(negedge clk);
    ign = "R9";
    op = 2'd3; d_in = 16'h4444; x_in = 16'h0; y_in = 16'h3333;
    repeat (6) @(negedge clk);
    start = 1'b0;
    ign = "";
    while (!done) @(negedge clk);
    // mixed patterns
    for (int i = 0; i < 60; i++) begin
      logic [15:0] xr;
      xr = ($urandom % 8 == 0) ? 16'h0 : 16'($urandom);
      run_op(2'($urandom), 16'($urandom), xr, 16'($urandom));
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule